// File: doc/BRIEF.md
# CSI-2 Link Bring-up Sequencer

This block is the control engine that brings a camera-serial receiver link up and takes it down again. A start request turns on the pixel clock enable and picks the PHY high-speed frequency range from the per-lane rate. It then writes the lane-count field, releases three active-low controls one per cycle (PHY shutdown, then D-PHY reset, then controller reset), and waits for the clock lane and every active data lane to report the low-power stop state. Only after that does it ask the sensor to transmit. Last, it waits for the clock lane to show a high-speed clock. Each of the two waits has a cycle-count limit. A failure unwinds only the steps already taken, in reverse order, and reports a result code.

Start and stop requests are reference counted. Only the start that moves the count from 0 to 1 and the stop that moves it from 1 to 0 touch the hardware controls. Every other request is answered at once with a result code. Requests that arrive while a sequence is in flight are ignored. If start and stop arrive in the same cycle, start wins.

States: `ST_IDLE` (link off) goes to `ST_CLKEN` on an accepted start. `ST_CLKEN` latches the range and goes to `ST_LANES`, or to `ST_UN_CLK` if the rate is out of range. The path then runs `ST_LANES` → `ST_SHUT` → `ST_DRST` → `ST_CRST` → `ST_WSTOP`. `ST_WSTOP` goes to `ST_WCLK` when all lanes are stopped, or to `ST_UN_RST` on timeout. `ST_WCLK` goes to `ST_RUN` when the high-speed clock is seen, or to `ST_UN_SENS` on timeout. `ST_RUN` goes to `ST_UN_SENS` on the last stop. The unwind runs `ST_UN_SENS` → `ST_UN_RST` → `ST_UN_CLK` → `ST_IDLE`.

Top module: `csi_link_seq`

## Requirements
- R1: After reset, `phy_shutdown_n`, `dphy_rst_n`, `ctrl_rst_n`, `pix_clk_en`, `sensor_start` and `op_done` are 0, and `stream_count` is 0.
- R2: A start accepted while idle sets `lane_cfg` to `num_lanes`-1 before any control is released. It then releases `phy_shutdown_n`, `dphy_rst_n` and `ctrl_rst_n` in that order, one cycle apart. With the PHY status already satisfied, `op_done` is high with code 0 in the 8th cycle after the start edge.
- R3: The stop-state wait needs status bit 10 (clock-lane stop) and bit 4+n (data lane n stop) for every n below `num_lanes`, all set at once. All other status bits are ignored. `sensor_start` rises only after this wait passes.
- R4: After `sensor_start` rises, status bit 8 (high-speed clock active) completes the start: `op_done` with code 0 and `stream_count` = 1.
- R5: If the stop-state wait sees no match in `WAIT_CYCLES` cycles, the three controls drop together and then `pix_clk_en` drops. `sensor_start` never rises. The result is code 3, due `WAIT_CYCLES`+8 cycles after the start edge.
- R6: If the clock wait times out, `sensor_start` falls, then the three controls fall, then `pix_clk_en` falls, each one cycle after the last. The result is code 4, due `WAIT_CYCLES`+10 cycles after the start edge.
- R7: The range code comes from the first table entry whose upper rate is strictly greater than the rate. The rate is `rate_mbps`, or 849 when `rate_valid` is 0. Examples: 89 → 0x00, 90 → 0x20, 849 → 0x14, 999 → 0x74.
- R8: A rate of 1000 or more gives code 2 in the 3rd cycle. No control is released, and `pix_clk_en` ends low.
- R9: A start with `src_linked` or `out_linked` low gives code 1 in the 1st cycle. The count and all controls are left unchanged.
- R10: While streaming, a start raises the count by one and a stop with count above 1 lowers it. Both answer with code 0 in the 1st cycle and leave the controls unchanged. A stop at count 1 runs the shutdown: sensor off, then controls, then clock enable. It gives code 0 in the 4th cycle, with count 0.
- R11: A stop at count 0 gives code 6. A start at the maximum count gives code 5. In both cases the count is unchanged.
- R12: `pix_clk_en` rises on the start edge, before any control is released, and stays high until a stop or an unwind drops it last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | One-cycle start request |
| stop_req | input | 1 | One-cycle stop request |
| src_linked | input | 1 | A source is attached |
| out_linked | input | 1 | At least one output is attached |
| num_lanes | input | NL_W (3) | Active data lanes, 1..MAX_LANES |
| rate_valid | input | 1 | `rate_mbps` is meaningful |
| rate_mbps | input | RATE_W (11) | Per-lane rate in Mbps |
| phy_status | input | 11 | PHY state word |
| lane_cfg | output | LANE_W (2) | Lane-count field (lanes minus one) |
| phy_shutdown_n | output | 1 | PHY shutdown, active low |
| dphy_rst_n | output | 1 | D-PHY reset, active low |
| ctrl_rst_n | output | 1 | Controller reset, active low |
| pix_clk_en | output | 1 | Pixel clock enable |
| sensor_start | output | 1 | Request to the sensor to transmit |
| hs_range | output | 7 | High-speed frequency range code |
| op_done | output | 1 | One-cycle completion pulse |
| op_code | output | 3 | Result of the last request |
| stream_count | output | CNT_W (4) | Stream reference count |

## Verification
Every result is due a fixed number of cycles after the clock edge that samples the request. The latencies are 1 for answered-at-once requests, 3 for a bad rate, 4 for the last stop, 8 for a clean start, `WAIT_CYCLES`+8 for a stop-state timeout and `WAIT_CYCLES`+10 for a clock timeout. The bench raises a request, clears it at the next falling edge, and then counts falling edges until `op_done` shows. It compares that count with the latency above, so a result that comes early or late fails. While it waits, the bench watches each falling edge for the order in which the controls, the sensor request and the clock enable change.

// File: rtl/csi_seq_pkg.sv
package csi_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CLKEN, ST_LANES, ST_SHUT, ST_DRST, ST_CRST,
        ST_WSTOP, ST_WCLK, ST_RUN, ST_UN_SENS, ST_UN_RST, ST_UN_CLK
    } seq_state_t;

    typedef enum logic [2:0] {
        RC_OK            = 3'd0,
        RC_NOLINK        = 3'd1,
        RC_RATE          = 3'd2,
        RC_STOP_TMO      = 3'd3,
        RC_CLK_TMO       = 3'd4,
        RC_FULL          = 3'd5,
        RC_NOT_STREAMING = 3'd6
    } res_code_t;

    // status word layout (fixed by the PHY)
    localparam int STAT_W          = 11;
    localparam int STAT_LANE_STOP0 = 4;
    localparam int STAT_HS_CLK     = 8;
    localparam int STAT_CLK_STOP   = 10;

    localparam int SEL_W        = 7;
    localparam int DEFAULT_MBPS = 849;

endpackage

// File: rtl/csi_hsfreq_lut.sv
module csi_hsfreq_lut
    import csi_seq_pkg::*;
#(
    parameter int RATE_W = 11
) (
    input  logic              rate_valid,
    input  logic [RATE_W-1:0] rate_mbps,
    output logic [SEL_W-1:0]  sel,
    output logic              in_range
);
    localparam int N_ENT = 29;

    // upper rate limit of each band, ascending
    localparam logic [10:0] LIMIT [N_ENT] = '{
        11'd90,  11'd100, 11'd110, 11'd125, 11'd140, 11'd150, 11'd160,
        11'd180, 11'd200, 11'd210, 11'd240, 11'd250, 11'd270, 11'd300,
        11'd330, 11'd360, 11'd400, 11'd450, 11'd500, 11'd550, 11'd600,
        11'd650, 11'd700, 11'd750, 11'd800, 11'd850, 11'd900, 11'd950,
        11'd1000
    };
    localparam logic [SEL_W-1:0] CODE [N_ENT] = '{
        7'h00, 7'h20, 7'h40, 7'h02, 7'h22, 7'h42, 7'h04,
        7'h24, 7'h44, 7'h06, 7'h26, 7'h46, 7'h08, 7'h28,
        7'h48, 7'h2a, 7'h4a, 7'h0c, 7'h2c, 7'h0e, 7'h2e,
        7'h10, 7'h30, 7'h12, 7'h32, 7'h14, 7'h34, 7'h54,
        7'h74
    };

    logic [RATE_W-1:0] eff_rate;

    always_comb begin
        eff_rate = rate_valid ? rate_mbps : RATE_W'(DEFAULT_MBPS);
        in_range = 1'b0;
        sel      = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (!in_range && ({{(32-11){1'b0}}, LIMIT[i]} > 32'(eff_rate))) begin
                in_range = 1'b1;
                sel      = CODE[i];
            end
        end
    end

endmodule

// File: rtl/csi_wait_timer.sv
module csi_wait_timer #(
    parameter int WAIT_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(WAIT_CYCLES + 1);

    logic [TW-1:0] cnt;

    assign expired = run && (cnt == TW'(WAIT_CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (run && !expired)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/csi_link_seq.sv
module csi_link_seq
    import csi_seq_pkg::*;
#(
    parameter int MAX_LANES   = 4,
    parameter int WAIT_CYCLES = 64,
    parameter int CNT_W       = 4,
    parameter int RATE_W      = 11,
    localparam int LANE_W     = $clog2(MAX_LANES),
    localparam int NL_W       = LANE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              src_linked,
    input  logic              out_linked,
    input  logic [NL_W-1:0]   num_lanes,
    input  logic              rate_valid,
    input  logic [RATE_W-1:0] rate_mbps,
    input  logic [10:0]       phy_status,
    output logic [LANE_W-1:0] lane_cfg,
    output logic              phy_shutdown_n,
    output logic              dphy_rst_n,
    output logic              ctrl_rst_n,
    output logic              pix_clk_en,
    output logic              sensor_start,
    output logic [6:0]        hs_range,
    output logic              op_done,
    output logic [2:0]        op_code,
    output logic [CNT_W-1:0]  stream_count
);
    localparam logic [CNT_W-1:0] CNT_FULL = '1;

    seq_state_t state, nxt;
    res_code_t  fail_code;

    logic              linked;
    logic              lut_ok;
    logic [SEL_W-1:0]  lut_sel;
    logic [STAT_W-1:0] stop_need;
    logic              all_stop;
    logic              hs_seen;
    logic              in_wait;
    logic              tmo;
    logic [NL_W-1:0]   lanes_m1;
    logic              stat_unused;

    assign linked      = src_linked && out_linked;
    assign hs_seen     = phy_status[STAT_HS_CLK];
    assign in_wait     = (state == ST_WSTOP) || (state == ST_WCLK);
    assign lanes_m1    = num_lanes - 1'b1;
    assign stat_unused = ^{phy_status[3:0], phy_status[9]};

    // lanes that must show the stop state
    always_comb begin
        stop_need = '0;
        stop_need[STAT_CLK_STOP] = 1'b1;
        for (int n = 0; n < MAX_LANES; n++)
            if (32'(num_lanes) > n)
                stop_need[STAT_LANE_STOP0 + n] = 1'b1;
    end
    assign all_stop = ((phy_status & stop_need) == stop_need);

    csi_hsfreq_lut #(.RATE_W(RATE_W)) u_lut (
        .rate_valid (rate_valid),
        .rate_mbps  (rate_mbps),
        .sel        (lut_sel),
        .in_range   (lut_ok)
    );

    csi_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state != nxt),
        .run     (in_wait),
        .expired (tmo)
    );

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start_req && linked) nxt = ST_CLKEN;
            ST_CLKEN:   nxt = lut_ok ? ST_LANES : ST_UN_CLK;
            ST_LANES:   nxt = ST_SHUT;
            ST_SHUT:    nxt = ST_DRST;
            ST_DRST:    nxt = ST_CRST;
            ST_CRST:    nxt = ST_WSTOP;
            ST_WSTOP:   if (all_stop) nxt = ST_WCLK;
                        else if (tmo) nxt = ST_UN_RST;
            ST_WCLK:    if (hs_seen) nxt = ST_RUN;
                        else if (tmo) nxt = ST_UN_SENS;
            ST_RUN:     if (!start_req && stop_req && stream_count == CNT_W'(1))
                            nxt = ST_UN_SENS;
            ST_UN_SENS: nxt = ST_UN_RST;
            ST_UN_RST:  nxt = ST_UN_CLK;
            ST_UN_CLK:  nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs and count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_cfg       <= '0;
            phy_shutdown_n <= 1'b0;
            dphy_rst_n     <= 1'b0;
            ctrl_rst_n     <= 1'b0;
            pix_clk_en     <= 1'b0;
            sensor_start   <= 1'b0;
            hs_range       <= '0;
            op_done        <= 1'b0;
            op_code        <= RC_OK;
            stream_count   <= '0;
            fail_code      <= RC_OK;
        end else begin
            op_done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start_req) begin
                        if (!linked) begin
                            op_done <= 1'b1;
                            op_code <= RC_NOLINK;
                        end else begin
                            pix_clk_en <= 1'b1;
                            fail_code  <= RC_OK;
                        end
                    end else if (stop_req) begin
                        op_done <= 1'b1;
                        op_code <= RC_NOT_STREAMING;
                    end
                end
                ST_CLKEN: begin
                    hs_range <= lut_sel;
                    if (!lut_ok) fail_code <= RC_RATE;
                end
                ST_LANES: lane_cfg       <= lanes_m1[LANE_W-1:0];
                ST_SHUT:  phy_shutdown_n <= 1'b1;
                ST_DRST:  dphy_rst_n     <= 1'b1;
                ST_CRST:  ctrl_rst_n     <= 1'b1;
                ST_WSTOP: begin
                    if (all_stop)  sensor_start <= 1'b1;
                    else if (tmo)  fail_code    <= RC_STOP_TMO;
                end
                ST_WCLK: begin
                    if (hs_seen) begin
                        stream_count <= CNT_W'(1);
                        op_done      <= 1'b1;
                        op_code      <= RC_OK;
                    end else if (tmo) begin
                        fail_code <= RC_CLK_TMO;
                    end
                end
                ST_RUN: begin
                    if (start_req) begin
                        op_done <= 1'b1;
                        if (stream_count == CNT_FULL) begin
                            op_code <= RC_FULL;
                        end else begin
                            stream_count <= stream_count + 1'b1;
                            op_code      <= RC_OK;
                        end
                    end else if (stop_req) begin
                        if (stream_count > CNT_W'(1)) begin
                            stream_count <= stream_count - 1'b1;
                            op_done      <= 1'b1;
                            op_code      <= RC_OK;
                        end else begin
                            fail_code <= RC_OK;
                        end
                    end
                end
                ST_UN_SENS: sensor_start <= 1'b0;
                ST_UN_RST: begin
                    phy_shutdown_n <= 1'b0;
                    dphy_rst_n     <= 1'b0;
                    ctrl_rst_n     <= 1'b0;
                end
                ST_UN_CLK: begin
                    pix_clk_en   <= 1'b0;
                    stream_count <= '0;
                    op_done      <= 1'b1;
                    op_code      <= fail_code;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/csi_link_seq_chk.sv
module csi_link_seq_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             phy_shutdown_n,
    input logic             dphy_rst_n,
    input logic             ctrl_rst_n,
    input logic             pix_clk_en,
    input logic             sensor_start,
    input logic             op_done,
    input logic [CNT_W-1:0] stream_count
);
    // R2: D-PHY reset released only after the shutdown was released
    assert_dphy_after_shut_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dphy_rst_n) |-> $past(phy_shutdown_n));

    // R2: controller reset released only after the D-PHY reset
    assert_ctrl_after_dphy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_rst_n) |-> $past(dphy_rst_n));

    // R12: clock enable already on when the first control is released
    assert_clk_before_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_shutdown_n) |-> $past(pix_clk_en));

    // R3: sensor asked to transmit only with all controls released
    assert_sensor_after_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sensor_start) |-> (ctrl_rst_n && dphy_rst_n && phy_shutdown_n && pix_clk_en));

    // R6: controls drop together and only once the sensor request is gone
    assert_unwind_resets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phy_shutdown_n) |-> (!dphy_rst_n && !ctrl_rst_n && !sensor_start));

    // R12: clock enable is the last thing turned off
    assert_clk_last_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pix_clk_en) |-> (!phy_shutdown_n && !ctrl_rst_n && !sensor_start));

    // R10: count changes only together with a completion pulse
    assert_count_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stream_count != $past(stream_count)) |-> op_done);

endmodule

bind csi_link_seq csi_link_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .phy_shutdown_n (phy_shutdown_n),
    .dphy_rst_n     (dphy_rst_n),
    .ctrl_rst_n     (ctrl_rst_n),
    .pix_clk_en     (pix_clk_en),
    .sensor_start   (sensor_start),
    .op_done        (op_done),
    .stream_count   (stream_count)
);

// File: tb/csi_link_seq_test.sv
`timescale 1ns/1ps
module csi_link_seq_test;
    localparam int W     = 8;
    localparam int CNT_W = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_req = 1'b0, stop_req = 1'b0;
    logic        src_linked = 1'b1, out_linked = 1'b1;
    logic [2:0]  num_lanes = 3'd4;
    logic        rate_valid = 1'b0;
    logic [10:0] rate_mbps = '0;
    logic [10:0] phy_status = '0;
    logic [1:0]  lane_cfg;
    logic        phy_shutdown_n, dphy_rst_n, ctrl_rst_n, pix_clk_en, sensor_start;
    logic [6:0]  hs_range;
    logic        op_done;
    logic [2:0]  op_code;
    logic [CNT_W-1:0] stream_count;

    int total = 0, bad = 0;
    bit finished = 0;
    bit saw_sensor, saw_release, order_ok, pix_first;

    always #5 clk = ~clk;

    csi_link_seq #(.WAIT_CYCLES(W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
        .src_linked(src_linked), .out_linked(out_linked), .num_lanes(num_lanes),
        .rate_valid(rate_valid), .rate_mbps(rate_mbps), .phy_status(phy_status),
        .lane_cfg(lane_cfg), .phy_shutdown_n(phy_shutdown_n), .dphy_rst_n(dphy_rst_n),
        .ctrl_rst_n(ctrl_rst_n), .pix_clk_en(pix_clk_en), .sensor_start(sensor_start),
        .hs_range(hs_range), .op_done(op_done), .op_code(op_code),
        .stream_count(stream_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_sel(input bit v, input int r);
        int e = v ? r : 849;
        if (e < 90) return 'h00;   if (e < 100) return 'h20;  if (e < 110) return 'h40;
        if (e < 125) return 'h02;  if (e < 140) return 'h22;  if (e < 150) return 'h42;
        if (e < 160) return 'h04;  if (e < 180) return 'h24;  if (e < 200) return 'h44;
        if (e < 210) return 'h06;  if (e < 240) return 'h26;  if (e < 250) return 'h46;
        if (e < 270) return 'h08;  if (e < 300) return 'h28;  if (e < 330) return 'h48;
        if (e < 360) return 'h2a;  if (e < 400) return 'h4a;  if (e < 450) return 'h0c;
        if (e < 500) return 'h2c;  if (e < 550) return 'h0e;  if (e < 600) return 'h2e;
        if (e < 650) return 'h10;  if (e < 700) return 'h30;  if (e < 750) return 'h12;
        if (e < 800) return 'h32;  if (e < 850) return 'h14;  if (e < 900) return 'h34;
        if (e < 950) return 'h54;  if (e < 1000) return 'h74;
        return -1;
    endfunction

    // status word: clock stop bit 10, lane n stop bit 4+n, hs clock bit 8
    function automatic logic [10:0] stat(input int lanes, input bit hs);
        logic [10:0] s = '0;
        s[10] = 1'b1;
        for (int n = 0; n < lanes; n++) s[4+n] = 1'b1;
        s[8] = hs;
        return s;
    endfunction

    // issue one request, count falling edges until op_done, watch ordering
    task automatic do_op(input bit is_start, output int cyc, output int code);
        bit p_ctrl, p_pix;
        saw_sensor = 0; saw_release = 0; order_ok = 1; pix_first = 0;
        @(negedge clk);
        if (is_start) start_req = 1'b1; else stop_req = 1'b1;
        p_ctrl = ctrl_rst_n; p_pix = pix_clk_en;
        cyc = 0;
        while (cyc < 400) begin
            @(negedge clk);
            start_req = 1'b0; stop_req = 1'b0;
            cyc++;
            if (cyc == 1) pix_first = pix_clk_en;
            if (sensor_start) saw_sensor = 1;
            if (phy_shutdown_n) saw_release = 1;
            if (p_ctrl && !ctrl_rst_n && sensor_start) order_ok = 0;
            if (p_pix && !pix_clk_en && (ctrl_rst_n || sensor_start)) order_ok = 0;
            p_ctrl = ctrl_rst_n; p_pix = pix_clk_en;
            if (op_done) break;
        end
        code = op_code;
    endtask

    task automatic good_start(input int lanes, input bit v, input int r, input string req);
        int c, k;
        num_lanes = 3'(lanes); rate_valid = v; rate_mbps = 11'(r);
        phy_status = stat(lanes, 1'b1);
        do_op(1, c, k);
        chk(c == 8, {req, " start latency"}, c, 8);
        chk(k == 0, {req, " start code"}, k, 0);
        chk(int'(hs_range) == exp_sel(v, r), {req, " range"}, hs_range, exp_sel(v, r));
        chk(int'(lane_cfg) == lanes - 1, {req, " lane_cfg"}, lane_cfg, lanes - 1);
        chk(sensor_start && ctrl_rst_n && pix_first, {req, " link up"}, sensor_start, 1);
        chk(stream_count == 1, {req, " count"}, stream_count, 1);
    endtask

    task automatic last_stop(input string req);
        int c, k;
        do_op(0, c, k);
        chk(c == 4 && k == 0, {req, " R10 stop latency/code"}, c * 10 + k, 40);
        chk(order_ok && !pix_clk_en && !phy_shutdown_n && !sensor_start,
            {req, " R10 shutdown order"}, order_ok, 1);
        chk(stream_count == 0, {req, " R10 count zero"}, stream_count, 0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int c, k;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!phy_shutdown_n && !dphy_rst_n && !ctrl_rst_n && !pix_clk_en && !sensor_start
            && !op_done && stream_count == 0, "R1 reset state", 1, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 refused start
        src_linked = 1'b0;
        do_op(1, c, k);
        chk(c == 1 && k == 1, "R9 no-link code", c * 10 + k, 11);
        chk(stream_count == 0 && !pix_clk_en && !phy_shutdown_n, "R9 nothing moved", stream_count, 0);
        src_linked = 1'b1;

        // R11 stop while idle
        do_op(0, c, k);
        chk(c == 1 && k == 6 && stream_count == 0, "R11 idle stop", c * 10 + k, 16);

        // R2 R4 R7 R12 clean start, default rate
        good_start(4, 1'b0, 0, "R2 R4 R7 R12");

        // R10 reference counting, R11 full
        do_op(1, c, k);
        chk(c == 1 && k == 0 && stream_count == 2, "R10 second start", stream_count, 2);
        do_op(1, c, k);
        chk(stream_count == 3 && k == 0, "R10 third start", stream_count, 3);
        do_op(1, c, k);
        chk(k == 5 && stream_count == 3, "R11 full start", k, 5);
        do_op(0, c, k);
        chk(c == 1 && k == 0 && stream_count == 2 && sensor_start && ctrl_rst_n,
            "R10 inner stop", stream_count, 2);
        do_op(0, c, k);
        chk(stream_count == 1 && sensor_start, "R10 inner stop 2", stream_count, 1);
        last_stop("last");

        // R5 stop-state timeout: lane 1 missing
        num_lanes = 3'd2; phy_status = stat(1, 1'b1);
        do_op(1, c, k);
        chk(c == W + 8 && k == 3, "R5 stop timeout", c, W + 8);
        chk(!saw_sensor && order_ok && !pix_clk_en && !phy_shutdown_n, "R5 sensor untouched", saw_sensor, 0);

        // R3 only active lanes and clock stop matter
        num_lanes = 3'd2; phy_status = stat(2, 1'b1) | 11'h20f;
        do_op(1, c, k);
        chk(c == 8 && k == 0, "R3 inactive bits ignored", c, 8);
        last_stop("R3");

        // R6 clock timeout
        num_lanes = 3'd1; phy_status = stat(1, 1'b0);
        do_op(1, c, k);
        chk(c == W + 10 && k == 4, "R6 clock timeout", c, W + 10);
        chk(saw_sensor && order_ok && !sensor_start && !pix_clk_en, "R6 unwind order", order_ok, 1);

        // R8 rate out of range
        rate_valid = 1'b1; rate_mbps = 11'd1000; phy_status = stat(1, 1'b1);
        do_op(1, c, k);
        chk(c == 3 && k == 2, "R8 rate error", c * 10 + k, 32);
        chk(!saw_release && !pix_clk_en && stream_count == 0, "R8 no release", saw_release, 0);

        // R7 boundary rates
        good_start(1, 1'b1, 89, "R7 89");   last_stop("R7");
        good_start(2, 1'b1, 90, "R7 90");   last_stop("R7");
        good_start(3, 1'b1, 999, "R7 999"); last_stop("R7");

        // random mix
        for (int i = 0; i < 12; i++) begin
            int ln = 1 + int'($urandom % 4);
            int rr = int'($urandom % 1000);
            bit vv = 1'($urandom % 4 != 0);
            good_start(ln, vv, rr, "R2 R7 random");
            last_stop("random");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule